// File: doc/BRIEF.md
# Dual-Rate Programmable Output Divider

This block sits after a fast oscillator and turns its clock into two slower clocks. The primary output runs at the input rate divided by 1, 2, 4 or 8, chosen by a two-bit ratio code. The secondary output always runs at exactly half the primary rate. Both outputs have a 50% duty cycle, and each one also has a complementary copy.

The ratio code is sampled only on a rising edge of the primary output. A new ratio therefore starts a fresh period and never cuts short the period already in progress. The divide-by-1 ratio passes the input clock straight through, gated by reset.

An active-high master reset stops both dividers at once. While it is high, the true outputs are low and the complementary outputs are high. Reset does not replace the selected ratio. After reset is released, the primary output rises for the first time after N input cycles, and the secondary output rises with it.

Top module: `rate_divider`

## Requirements
- R1: Ratio code 2'b00 gives divide-by-1, 2'b01 gives divide-by-2, 2'b10 gives divide-by-4 and 2'b11 gives divide-by-8. A primary period is N input clock cycles long.
- R2: The secondary output toggles on every rising edge of the primary output and at no other time, so it runs at half the primary frequency.
- R3: The primary output is high for the first N/2 input cycles of each period and low for the rest. At divide-by-1 it is high exactly while the input clock is high.
- R4: While mr is high, fout and fhalf are low and fout_n and fhalf_n are high, whatever the input clock does.
- R5: After mr falls, the first rising edge of fout comes on the Nth rising input edge, and fhalf starts low and rises at that same edge.
- R6: Asserting mr does not replace the selected ratio. After release, the ratio present before reset applies again without being written again.
- R7: fout_n is always the inverse of fout, and fhalf_n is always the inverse of fhalf.
- R8: A change of the ratio code takes effect only at the next rising edge of fout. The current period completes at the old ratio, and no shortened high or low phase appears on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| mr | input | 1 | Master reset, active high |
| n_code | input | 2 | Ratio select: N = 2**n_code |
| fout | output | 1 | Primary divided clock |
| fout_n | output | 1 | Complement of fout |
| fhalf | output | 1 | Half-rate clock, toggles on fout rising edges |
| fhalf_n | output | 1 | Complement of fhalf |

## Verification
The sensitive cycle is the boundary edge. On that single input edge, fout rises, fhalf toggles and a new ratio is adopted. The bench changes the code in the middle of a low phase and in the middle of a high phase, and also switches into and out of the divide-by-1 pass-through. It records every edge that follows. Each check requires the old period to finish at full length, the new period to begin on the same edge that toggles fhalf, and no extra edge to appear on either output.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;

  // Counter width needed for the largest ratio 2**(2**code_w - 1).
  function automatic int cnt_width(input int code_w);
    int w;
    w = (1 << code_w) - 1;
    return (w > 0) ? w : 1;
  endfunction

  // Period events handed from the phase counter to the wave shaper.
  typedef struct packed {
    logic rise;   // next edge starts a new period
    logic fall;   // next edge reaches the midpoint
  } rdiv_evt_t;

endpackage

// File: rtl/rdiv_phase.sv
`timescale 1ns/1ps
module rdiv_phase #(
  parameter int CODE_W = 2
) (
  input  logic                   clk_in,
  input  logic                   mr,
  input  logic [CODE_W-1:0]      n_code,
  output logic [CODE_W-1:0]      act_k,
  output rdiv_pkg::rdiv_evt_t    evt
);
  localparam int CNT_W = rdiv_pkg::cnt_width(CODE_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] half;

  always_comb begin
    mask     = CNT_W'((32'd1 << act_k) - 32'd1);
    half     = (mask >> 1) + CNT_W'(1);
    cnt_nx   = (cnt_q + CNT_W'(1)) & mask;
    evt.rise = (cnt_nx == '0);
    evt.fall = !evt.rise && (cnt_nx == half);
  end

  // Position inside the current period; held at zero during reset.
  always_ff @(posedge clk_in or posedge mr) begin
    if (mr) cnt_q <= '0;
    else    cnt_q <= cnt_nx;
  end

  // Active ratio: follows the code only during reset or at a period start.
  always_ff @(posedge clk_in) begin
    if (mr || evt.rise) act_k <= n_code;
  end

endmodule

// File: rtl/rdiv_wave.sv
`timescale 1ns/1ps
module rdiv_wave (
  input  logic                clk_in,
  input  logic                mr,
  input  rdiv_pkg::rdiv_evt_t evt,
  output logic                fout_q,
  output logic                fhalf_q
);
  always_ff @(posedge clk_in or posedge mr) begin
    if (mr) begin
      fout_q  <= 1'b0;
      fhalf_q <= 1'b0;
    end else if (evt.rise) begin
      fout_q  <= 1'b1;
      fhalf_q <= ~fhalf_q;
    end else if (evt.fall) begin
      fout_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
module rate_divider #(
  parameter int CODE_W = 2
) (
  input  logic              clk_in,
  input  logic              mr,
  input  logic [CODE_W-1:0] n_code,
  output logic              fout,
  output logic              fout_n,
  output logic              fhalf,
  output logic              fhalf_n
);
  logic [CODE_W-1:0]   act_k;
  rdiv_pkg::rdiv_evt_t evt;
  logic                fout_q;
  logic                fhalf_q;
  logic                bypass;
  logic [1:0]          true_pair;
  logic [1:0]          comp_pair;

  rdiv_phase #(.CODE_W(CODE_W)) u_phase (
    .clk_in (clk_in),
    .mr     (mr),
    .n_code (n_code),
    .act_k  (act_k),
    .evt    (evt)
  );

  rdiv_wave u_wave (
    .clk_in  (clk_in),
    .mr      (mr),
    .evt     (evt),
    .fout_q  (fout_q),
    .fhalf_q (fhalf_q)
  );

  // Divide-by-1 passes the input clock through, gated by reset.
  assign bypass       = (act_k == '0);
  assign true_pair[0] = bypass ? (clk_in & ~mr) : fout_q;
  assign true_pair[1] = fhalf_q;

  for (genvar g = 0; g < 2; g++) begin : g_comp
    assign comp_pair[g] = ~true_pair[g];
  end

  assign fout    = true_pair[0];
  assign fhalf   = true_pair[1];
  assign fout_n  = comp_pair[0];
  assign fhalf_n = comp_pair[1];

endmodule

// File: rtl/rdiv_check.sv
`timescale 1ns/1ps
module rdiv_check #(
  parameter int CODE_W = 2
) (
  input logic              clk,
  input logic              mr,
  input logic              fout,
  input logic              fout_n,
  input logic              fhalf,
  input logic              fhalf_n,
  input logic              fq,
  input logic              fh,
  input logic [CODE_W-1:0] k
);
  AST_RESET_LEVELS: assert property (@(posedge clk)
    mr |-> (!fout && fout_n && !fhalf && fhalf_n)); // R4

  AST_RELEASE_LOW: assert property (@(posedge clk)
    $fell(mr) |-> (!fq && !fh)); // R5

  AST_HALF_ON_RISE: assert property (@(posedge clk) disable iff (mr)
    (fh != $past(fh)) |-> (fq && (!$past(fq) || $past(k) == '0))); // R2

  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (mr)
    (!$past(mr) && k != $past(k)) |-> (fq && (!$past(fq) || $past(k) == '0))); // R8

  AST_DIV2_DUTY: assert property (@(posedge clk) disable iff (mr)
    ($rose(fq) && k == CODE_W'(1)) |=> !fq); // R3

  AST_DIV4_HOLD: assert property (@(posedge clk) disable iff (mr)
    ($rose(fq) && k == CODE_W'(2)) |=> fq); // R1
endmodule

bind rate_divider rdiv_check #(.CODE_W(CODE_W)) u_rdiv_check (
  .clk     (clk_in),
  .mr      (mr),
  .fout    (fout),
  .fout_n  (fout_n),
  .fhalf   (fhalf),
  .fhalf_n (fhalf_n),
  .fq      (fout_q),
  .fh      (fhalf_q),
  .k       (act_k)
);

// File: tb/rate_divider_bench.sv
`timescale 1ns/1ps
module rate_divider_bench;
  logic       clk_in;
  logic       mr;
  logic [1:0] n_code;
  logic       fout, fout_n, fhalf, fhalf_n;
  int         n_tests = 0;
  int         n_fail  = 0;
  int         compl_bad = 0;
  bit         done = 0;
  logic [15:0] got_f, got_h;

  rate_divider u_rate_divider (
    .clk_in (clk_in), .mr (mr), .n_code (n_code),
    .fout (fout), .fout_n (fout_n), .fhalf (fhalf), .fhalf_n (fhalf_n)
  );

  initial clk_in = 1'b0;
  always #2.5 clk_in = ~clk_in;

  // {code, fout on edges 1..16 (LSB = edge 1), fhalf on edges 1..16}
  localparam logic [33:0] VEC [0:3] = '{
    {2'b00, 16'hFFFF, 16'h5555},
    {2'b01, 16'hAAAA, 16'h6666},
    {2'b10, 16'h9998, 16'h7878},
    {2'b11, 16'h8780, 16'h7F80}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] code);
    @(negedge clk_in);
    mr = 1'b1;
    n_code = code;
    repeat (2) @(negedge clk_in);
    mr = 1'b0;
  endtask

  task automatic record(input int count);
    got_f = '0;
    got_h = '0;
    for (int j = 0; j < count; j++) begin
      @(posedge clk_in);
      #1;
      got_f[j] = fout;
      got_h[j] = fhalf;
      if (fout_n !== ~fout || fhalf_n !== ~fhalf) compl_bad++;
    end
  endtask

  initial begin
    mr = 1'b1;
    n_code = 2'b00;
    repeat (3) @(posedge clk_in);
    #1;
    chk("R4", "levels in reset, clock high", {28'd0, fout, fout_n, fhalf, fhalf_n}, 32'b0101);
    @(negedge clk_in);
    #1;
    chk("R4", "levels in reset, clock low", {28'd0, fout, fout_n, fhalf, fhalf_n}, 32'b0101);

    // Table walk: every ratio from reset release
    for (int v = 0; v < 4; v++) begin
      restart(VEC[v][33:32]);
      record(16);
      chk("R1 R3 R5", $sformatf("fout pattern code %0d", v), {16'd0, got_f}, {16'd0, VEC[v][31:16]});
      chk("R2 R5", $sformatf("fhalf pattern code %0d", v), {16'd0, got_h}, {16'd0, VEC[v][15:0]});
    end

    // Divide-by-1 low phase follows the input clock
    restart(2'b00);
    @(posedge clk_in);
    @(negedge clk_in);
    #1;
    chk("R3", "bypass low phase", {31'd0, fout}, 32'd0);

    // Reset mid-run keeps ratio 4
    restart(2'b10);
    repeat (6) @(posedge clk_in);
    @(negedge clk_in);
    mr = 1'b1;
    @(posedge clk_in);
    #1;
    chk("R4", "mid-run reset forces levels", {28'd0, fout, fout_n, fhalf, fhalf_n}, 32'b0101);
    repeat (2) @(negedge clk_in);
    mr = 1'b0;
    record(16);
    chk("R6", "ratio kept through reset", {16'd0, got_f}, 32'h9998);

    // Change 2 -> 8 during a low phase
    restart(2'b01);
    repeat (3) @(posedge clk_in);
    @(negedge clk_in);
    n_code = 2'b11;
    record(9);
    chk("R8", "fout after 2->8 change", {16'd0, got_f}, 32'h10F);
    chk("R8", "fhalf after 2->8 change", {16'd0, got_h}, 32'h100);

    // Change 8 -> 2 during a high phase
    restart(2'b11);
    repeat (9) @(posedge clk_in);
    @(negedge clk_in);
    n_code = 2'b01;
    record(9);
    chk("R8", "fout after 8->2 change", {16'd0, got_f}, 32'h143);
    chk("R8", "fhalf after 8->2 change", {16'd0, got_h}, 32'h13F);

    // Leave pass-through for divide-by-4
    restart(2'b00);
    repeat (3) @(posedge clk_in);
    @(negedge clk_in);
    n_code = 2'b10;
    record(5);
    chk("R8", "fout after 1->4 change", {16'd0, got_f}, 32'h13);
    chk("R8", "fhalf after 1->4 change", {16'd0, got_h}, 32'h10);

    chk("R7", "complement mismatches", compl_bad, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule